// File: doc/BRIEF.md
# Serial Peripheral Port with Error Flags

This block is a byte-wide serial peripheral port that a processor drives through a small register bus. It can be the clock master of a four-wire serial link or a slave framed by an active-low select input. On transmit the data register is the shift register itself, with no extra buffering. On receive a finished character moves from the shift register into a read buffer, so the processor has one full character time to fetch it.

Four sticky flags record events: transfer complete, receive overrun, write collision and mode fault. Each flag stays set until software writes a 0 to its bit, or until reset. A single enable bit joins the four flags into one interrupt request. Error handling is the same in both roles. A data write that arrives while a transfer is running is dropped, and the transfer goes on untouched. A character that completes while the read buffer is still unread is dropped, and the older character stays in the buffer.

Register map (2-bit address): 0 is data (a write loads the shifter, a read returns the read buffer), 1 is control/status, 2 is configuration, 3 is the clock divider. Control/status bits: 0 port enable, 1 master select, 2 busy (read only), 3 mode fault, 4 write collision, 5 receive overrun, 6 transfer complete, 7 read buffer full (read only). Configuration bits: 0 clock polarity (the idle level of the serial clock), 1 interrupt enable.

Top module: `spiPort`

## Requirements
- R1: After reset, the control/status, configuration and divider registers all read 0x00, `irq` is 0 and `sclkOut` is 0.
- R2: In master mode (control bits 0 and 1 set), a data write while not busy starts a transfer and sets busy. Eight bits are sent MSB first on `mosiOut`, and each bit is valid on the leading `sclkOut` edge. `misoIn` is sampled on the leading edges and the shift happens on the trailing edges. The serial clock period is 2*(divider+1) system clocks. Busy clears and the complete flag sets 16*(divider+1) cycles after the write edge.
- R3: Configuration bit 0 sets the idle level of `sclkOut`. The leading edge is always the one that leaves the idle level, and transfers behave the same for either polarity.
- R4: If the read buffer is read before the next character completes, the new character is stored and no overrun is flagged. A data read clears the buffer-full bit.
- R5: If a character completes while the buffer is full and no read happens in that cycle, the overrun flag sets, the new character is dropped and the old one stays readable.
- R6: A data write while busy is discarded. The transfer continues with its original data and the collision flag sets. This holds in master and in slave mode.
- R7: In slave mode (enable set, master clear), a falling `ssNIn` sets busy. `mosiIn` is sampled on leading `sclkIn` edges, `misoOut` presents the loaded character MSB first, and busy clears after the eighth leading edge, with the received character stored.
- R8: The mode-fault flag sets when `ssNIn` falls while the port is enabled as master.
- R9: Writing 0 to a flag bit clears it and writing 1 leaves it. A flag set by hardware in the same cycle as a software clear stays set.
- R10: `irq` is 1 exactly when the interrupt enable is set and at least one of the four flags is set.
- R11: A data read in the same cycle that a character completes into a full buffer returns the old character, stores the new one and flags no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| sclkOut | output | 1 | Serial clock driven in master mode |
| mosiOut | output | 1 | Serial data out in master mode |
| misoIn | input | 1 | Serial data in for master mode |
| sclkIn | input | 1 | Serial clock in for slave mode |
| ssNIn | input | 1 | Active-low slave select |
| mosiIn | input | 1 | Serial data in for slave mode |
| misoOut | output | 1 | Serial data out in slave mode |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of events can fall on the same clock edge. A hardware flag set can meet a software clear of that flag, and a character completion can meet a data read of a full buffer. The bench counts cycles from the edge that starts a master transfer, 16*(divider+1), and places the status write or the data read exactly on the completion edge. For the first pair it then expects the complete flag to survive, and a second clear to remove it. For the second pair it expects the read to return the older character, the next read to return the newer one, and the overrun flag to stay 0.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int CHAR_W = 8;
  localparam int DIV_W  = BUS_W;
  localparam int EDGE_W = $clog2(2 * CHAR_W);
  localparam int BIT_W  = $clog2(CHAR_W);

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd3;

  localparam int BIT_EN     = 0;
  localparam int BIT_MASTER = 1;
  localparam int BIT_MODF   = 3;
  localparam int BIT_WCOL   = 4;
  localparam int BIT_ROVR   = 5;
  localparam int BIT_DONE   = 6;

  localparam int CFG_POL   = 0;
  localparam int CFG_IRQEN = 1;

  typedef struct packed {
    logic loadTx;
    logic sample;
    logic shift;
    logic done;
    logic doneDirect;
    logic storeRx;
    logic rdTake;
    logic inBit;
  } shiftStrobe_t;
endpackage

// File: rtl/spiPortSync.sv
`timescale 1ns/1ps
module spiPortSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_VAL;
        else       stageQ[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_VAL;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/spiPortCtrl.sv
`timescale 1ns/1ps
module spiPortCtrl
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxFull,
  input  logic              sclkIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              sclkOut,
  output logic              masterMode,
  output logic              irq,
  output shiftStrobe_t      stb
);
  logic portEn, isMaster, clkPol, irqEn;
  logic [DIV_W-1:0] divVal, divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [BIT_W-1:0] bitCnt;
  logic sclkPhase, busy;
  logic fModf, fWcol, fRovr, fDone;
  logic sclkS, ssNS, mosiS, sclkPrev, ssNPrev;

  spiPortSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) uSync (
    .clk(clk), .rstN(rstN),
    .din({sclkIn, ssNIn, mosiIn}),
    .dout({sclkS, ssNS, mosiS})
  );

  // bus decode
  logic wrData, wrCtrl, wrCfg, wrDiv, rdData;
  assign wrData = busSel && busWr && (busAddr == ADDR_DATA);
  assign wrCtrl = busSel && busWr && (busAddr == ADDR_CTRL);
  assign wrCfg  = busSel && busWr && (busAddr == ADDR_CFG);
  assign wrDiv  = busSel && busWr && (busAddr == ADDR_DIV);
  assign rdData = busSel && !busWr && (busAddr == ADDR_DATA);

  logic masterRun, slaveRun, loadNow, collideNow, startMaster;
  assign masterRun   = portEn && isMaster;
  assign slaveRun    = portEn && !isMaster;
  assign loadNow     = wrData && !busy;
  assign collideNow  = wrData && busy;
  assign startMaster = loadNow && masterRun;

  // master edge generation
  logic tick, mLead, mTrail, mDone;
  assign tick   = busy && masterRun && (divCnt == divVal);
  assign mLead  = tick && !edgeCnt[0];
  assign mTrail = tick && edgeCnt[0];
  assign mDone  = mTrail && (edgeCnt == EDGE_W'(2 * CHAR_W - 1));

  // slave edge detection
  logic ssFall, ssRise, sLevel, sLevelPrev, sLead, sTrail, sDone;
  assign ssFall     = ssNPrev && !ssNS;
  assign ssRise     = !ssNPrev && ssNS;
  assign sLevel     = sclkS ^ clkPol;
  assign sLevelPrev = sclkPrev ^ clkPol;
  assign sLead      = slaveRun && busy && !ssNS && !sLevelPrev && sLevel;
  assign sTrail     = slaveRun && busy && !ssNS && sLevelPrev && !sLevel;
  assign sDone      = sLead && (bitCnt == BIT_W'(CHAR_W - 1));

  logic doneNow, overrunNow, modfNow;
  assign doneNow    = mDone || sDone;
  assign overrunNow = doneNow && rxFull && !rdData;
  assign modfNow    = masterRun && ssFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portEn <= 1'b0; isMaster <= 1'b0; clkPol <= 1'b0; irqEn <= 1'b0;
      divVal <= '0;
    end else begin
      if (wrCtrl) begin
        portEn   <= busWdata[BIT_EN];
        isMaster <= busWdata[BIT_MASTER];
      end
      if (wrCfg) begin
        clkPol <= busWdata[CFG_POL];
        irqEn  <= busWdata[CFG_IRQEN];
      end
      if (wrDiv) divVal <= busWdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (!portEn) begin
      busy <= 1'b0;
    end else if (startMaster) begin
      busy <= 1'b1;
    end else if (doneNow) begin
      busy <= 1'b0;
    end else if (slaveRun && ssFall) begin
      busy <= 1'b1;
    end else if (slaveRun && ssRise) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; edgeCnt <= '0; sclkPhase <= 1'b0; bitCnt <= '0;
      sclkPrev <= 1'b0; ssNPrev <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      ssNPrev  <= ssNS;
      if (startMaster) begin
        divCnt <= '0; edgeCnt <= '0; sclkPhase <= 1'b0;
      end else if (busy && masterRun) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          edgeCnt   <= edgeCnt + 1'b1;
          sclkPhase <= !sclkPhase;
        end
      end
      if (slaveRun && ssFall) bitCnt <= '0;
      else if (sLead)         bitCnt <= bitCnt + 1'b1;
    end
  end

  // sticky flags: write 0 clears, a hardware set in the same cycle wins
  logic [BUS_W-1:0] keepMask;
  assign keepMask = wrCtrl ? busWdata : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fModf <= 1'b0; fWcol <= 1'b0; fRovr <= 1'b0; fDone <= 1'b0;
    end else begin
      fModf <= (fModf && keepMask[BIT_MODF]) || modfNow;
      fWcol <= (fWcol && keepMask[BIT_WCOL]) || collideNow;
      fRovr <= (fRovr && keepMask[BIT_ROVR]) || overrunNow;
      fDone <= (fDone && keepMask[BIT_DONE]) || doneNow;
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_DATA: busRdata = rxData;
      ADDR_CTRL: busRdata = {rxFull, fDone, fRovr, fWcol, fModf, busy, isMaster, portEn};
      ADDR_CFG:  busRdata = {{(BUS_W-2){1'b0}}, irqEn, clkPol};
      default:   busRdata = divVal;
    endcase
  end

  assign sclkOut    = clkPol ^ (sclkPhase && busy);
  assign masterMode = isMaster;
  assign irq        = irqEn && (fModf || fWcol || fRovr || fDone);

  always_comb begin
    stb            = '0;
    stb.loadTx     = loadNow;
    stb.sample     = mLead || sLead;
    stb.shift      = mTrail || sTrail;
    stb.done       = doneNow;
    stb.doneDirect = sDone;
    stb.storeRx    = doneNow && (!rxFull || rdData);
    stb.rdTake     = rdData;
    stb.inBit      = isMaster ? misoIn : mosiS;
  end

  // R6: a colliding write does not end or restart the running transfer
  a_r6_busy_survives: assert property (@(posedge clk) disable iff (!rstN)
    (collideNow && !doneNow && !wrCtrl && !(slaveRun && ssRise)) |=> busy);

  // R9: a complete flag only drops after a software write of 0
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fDone && !(wrCtrl && !busWdata[BIT_DONE])) |=> fDone);

  // R2: between divider ticks the serial clock does not move
  a_r2_clock_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && masterRun && !tick && !wrCfg && !wrCtrl) |=> $stable(sclkOut));
endmodule

// File: rtl/spiPortData.sv
`timescale 1ns/1ps
module spiPortData
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      stb,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxFull,
  output logic              txBit
);
  logic [CHAR_W-1:0] shiftQ, rxBuf, newChar;
  logic sampleQ;

  assign newChar = stb.doneDirect ? {shiftQ[CHAR_W-2:0], stb.inBit}
                                  : {shiftQ[CHAR_W-2:0], sampleQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0; sampleQ <= 1'b0; rxBuf <= '0; rxFull <= 1'b0;
    end else begin
      if (stb.loadTx)     shiftQ <= busWdata[CHAR_W-1:0];
      else if (stb.shift) shiftQ <= {shiftQ[CHAR_W-2:0], sampleQ};
      if (stb.sample) sampleQ <= stb.inBit;
      if (stb.storeRx) begin
        rxBuf  <= newChar;
        rxFull <= 1'b1;
      end else if (stb.rdTake) begin
        rxFull <= 1'b0;
      end
    end
  end

  assign rxData = rxBuf;
  assign txBit  = shiftQ[CHAR_W-1];

  // R5: a completion into a full, unread buffer leaves the buffer as it was
  a_r5_old_char_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.done && rxFull && !stb.rdTake) |=> $stable(rxBuf));

  // R4: a read with no completion empties the buffer
  a_r4_read_empties: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdTake && !stb.done) |=> !rxFull);

  // R6: a load never coincides with a shift edge of a running transfer
  a_r6_load_isolated: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |-> !stb.shift && !stb.sample);
endmodule

// File: rtl/spiPort.sv
`timescale 1ns/1ps
module spiPort
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              sclkOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sclkIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              irq
);
  shiftStrobe_t stb;
  logic [CHAR_W-1:0] rxData;
  logic rxFull, txBit, masterMode;

  spiPortCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .rxData(rxData), .rxFull(rxFull),
    .sclkIn(sclkIn), .ssNIn(ssNIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .sclkOut(sclkOut), .masterMode(masterMode), .irq(irq), .stb(stb)
  );

  spiPortData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .rxData(rxData), .rxFull(rxFull), .txBit(txBit)
  );

  assign mosiOut = masterMode && txBit;
  assign misoOut = !masterMode && txBit;
endmodule

// File: tb/spiPort_test.sv
`timescale 1ns/1ps
module spiPort_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, busSel, busWr;
  logic [1:0] busAddr;
  logic [7:0] busWdata, busRdata;
  logic sclkOut, mosiOut, misoIn, sclkIn, ssNIn, mosiIn, misoOut, irq;

  spiPort uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclkOut(sclkOut), .mosiOut(mosiOut),
    .misoIn(misoIn), .sclkIn(sclkIn), .ssNIn(ssNIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // external device model for master mode
  logic [7:0] devShift = 8'h00;
  logic [7:0] devRx = 8'h00;
  logic cfgPol = 1'b0;
  always @(sclkOut) begin
    if ((sclkOut ^ cfgPol) == 1'b1) devRx = {devRx[6:0], mosiOut};
    else devShift = {devShift[6:0], 1'b0};
  end
  assign misoIn = devShift[7];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0;
  endtask

  function automatic logic [7:0] stBit(input logic [7:0] st, input int pos);
    return {7'd0, st[pos]};
  endfunction

  function automatic int xferCycles(input int div);
    return 16 * (div + 1);
  endfunction

  // master transfer; returns at the negedge right after completion + margin
  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] dev, input int div,
                            input bit doRead, input string tag);
    logic [7:0] st, d;
    devShift = dev; devRx = 8'h00;
    busWrite(2'd0, tx);
    busRead(2'd1, st);
    check({tag, " R2 busy after start"}, stBit(st, 2), 8'd1);
    repeat (xferCycles(div)) @(negedge clk);
    busRead(2'd1, st);
    check({tag, " R2 busy cleared"}, stBit(st, 2), 8'd0);
    check({tag, " R2 complete flag"}, stBit(st, 6), 8'd1);
    check({tag, " R2 mosi char"}, devRx, tx);
    if (doRead) begin
      busRead(2'd0, d);
      check({tag, " R2 received char"}, d, dev);
    end
    busWrite(2'd1, 8'hBF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d, got, tx, dev, sTx, sRx;
    int div;
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = 2'd0; busWdata = 8'h00;
    sclkIn = 1'b0; ssNIn = 1'b1; mosiIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd1, st); check("R1 control/status", st, 8'h00);
    busRead(2'd2, st); check("R1 configuration", st, 8'h00);
    busRead(2'd3, st); check("R1 divider", st, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 sclk idle", sclkOut, 1'b0);

    // R2 directed master transfer, divide by 16
    div = 7;
    busWrite(2'd3, 8'(div));
    busWrite(2'd1, 8'h03);
    masterXfer(8'hA5, 8'h3C, div, 1'b1, "dir");

    // R2 exact completion edge: busy still 1 one cycle before
    devShift = 8'h81; devRx = 8'h00;
    busWrite(2'd0, 8'h5A);
    repeat (xferCycles(div) - 2) @(negedge clk);
    busRead(2'd1, st);
    check("R2 busy until last edge", stBit(st, 2), 8'd1);
    @(negedge clk);
    busRead(2'd1, st);
    check("R2 busy cleared on time", stBit(st, 2), 8'd0);
    busRead(2'd0, d);
    check("R2 char on time", d, 8'h81);
    busWrite(2'd1, 8'h03);

    // R3 inverted polarity
    cfgPol = 1'b1;
    busWrite(2'd2, 8'h01);
    @(negedge clk);
    check("R3 idle high", sclkOut, 1'b1);
    masterXfer(8'hC3, 8'h96, div, 1'b1, "pol");
    check("R3 idle high after", sclkOut, 1'b1);
    cfgPol = 1'b0;
    busWrite(2'd2, 8'h00);

    // R5 overrun: two chars without reading
    div = 1;
    busWrite(2'd3, 8'(div));
    masterXfer(8'h11, 8'h22, div, 1'b0, "ovr1");
    masterXfer(8'h33, 8'h44, div, 1'b0, "ovr2");
    busRead(2'd1, st);
    check("R5 overrun set", stBit(st, 5), 8'd1);
    busRead(2'd0, d);
    check("R5 old char kept", d, 8'h22);
    busRead(2'd1, st);
    check("R4 buffer empty after read", stBit(st, 7), 8'd0);
    // R10 flag with interrupt disabled, then enabled
    check("R10 irq masked", irq, 1'b0);
    busWrite(2'd2, 8'h02);
    @(negedge clk);
    check("R10 irq from overrun", irq, 1'b1);
    busWrite(2'd1, 8'h03);
    @(negedge clk);
    check("R10 irq after clear", irq, 1'b0);
    busRead(2'd1, st);
    check("R9 flags cleared", st & 8'h78, 8'h00);
    busWrite(2'd2, 8'h00);

    // R4 read between transfers -> no overrun
    masterXfer(8'h55, 8'h66, div, 1'b1, "r4a");
    masterXfer(8'h77, 8'h88, div, 1'b1, "r4b");
    busRead(2'd1, st);
    check("R4 no overrun", stBit(st, 5), 8'd0);

    // R9 set wins over clear on the same edge
    devShift = 8'hE7; devRx = 8'h00;
    busWrite(2'd0, 8'h18);
    repeat (xferCycles(div) - 1) @(negedge clk);
    busWrite(2'd1, 8'hBF);
    busRead(2'd1, st);
    check("R9 set beats clear", stBit(st, 6), 8'd1);
    busWrite(2'd1, 8'hBF);
    busRead(2'd1, st);
    check("R9 clear by write 0", stBit(st, 6), 8'd0);
    check("R9 write 1 keeps full", stBit(st, 7), 8'd1);

    // R11 read on completion edge with full buffer (buffer holds E7)
    devShift = 8'h4D; devRx = 8'h00;
    busWrite(2'd0, 8'h99);
    repeat (xferCycles(div) - 1) @(negedge clk);
    busRead(2'd0, d);
    check("R11 read returns old", d, 8'hE7);
    busRead(2'd1, st);
    check("R11 no overrun", stBit(st, 5), 8'd0);
    busRead(2'd0, d);
    check("R11 new char stored", d, 8'h4D);
    busWrite(2'd1, 8'h03);

    // R6 write collision in master mode
    div = 3;
    busWrite(2'd3, 8'(div));
    devShift = 8'h0F; devRx = 8'h00;
    busWrite(2'd0, 8'hB2);
    repeat (5) @(negedge clk);
    busWrite(2'd0, 8'h4E);
    repeat (xferCycles(div)) @(negedge clk);
    check("R6 master tx unchanged", devRx, 8'hB2);
    busRead(2'd1, st);
    check("R6 master collision flag", stBit(st, 4), 8'd1);
    busRead(2'd0, d);
    check("R6 master rx intact", d, 8'h0F);
    busWrite(2'd1, 8'h03);

    // R8 mode fault
    busWrite(2'd2, 8'h02);
    ssNIn = 1'b0;
    repeat (6) @(negedge clk);
    busRead(2'd1, st);
    check("R8 mode fault", stBit(st, 3), 8'd1);
    check("R10 irq from mode fault", irq, 1'b1);
    ssNIn = 1'b1;
    repeat (4) @(negedge clk);
    busWrite(2'd1, 8'h03);
    busWrite(2'd2, 8'h00);

    // R7 slave transfer with a colliding write (R6)
    busWrite(2'd1, 8'h01);
    sTx = 8'hC9; sRx = 8'h6B; got = 8'h00;
    busWrite(2'd0, sTx);
    ssNIn = 1'b0;
    repeat (8) @(negedge clk);
    busRead(2'd1, st);
    check("R7 slave busy on select", stBit(st, 2), 8'd1);
    for (int i = 0; i < 8; i++) begin
      mosiIn = sRx[7-i];
      repeat (8) @(negedge clk);
      got[7-i] = misoOut;
      sclkIn = 1'b1;
      repeat (8) @(negedge clk);
      if (i == 3) busWrite(2'd0, 8'hFF);
      sclkIn = 1'b0;
      repeat (8) @(negedge clk);
    end
    check("R7 miso char", got, sTx);
    busRead(2'd1, st);
    check("R7 slave busy cleared", stBit(st, 2), 8'd0);
    check("R7 slave complete", stBit(st, 6), 8'd1);
    check("R6 slave collision flag", stBit(st, 4), 8'd1);
    busRead(2'd0, d);
    check("R7 slave received", d, sRx);
    ssNIn = 1'b1;
    repeat (4) @(negedge clk);
    busWrite(2'd1, 8'h03);

    // R2/R3 random master transfers
    void'($urandom(32'd4711));
    for (int n = 0; n < 20; n++) begin
      div = int'($urandom_range(0, 3));
      cfgPol = 1'($urandom_range(0, 1));
      tx = 8'($urandom); dev = 8'($urandom);
      busWrite(2'd3, 8'(div));
      busWrite(2'd2, {7'd0, cfgPol});
      masterXfer(tx, dev, div, 1'b1, "rnd R3");
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule